// File: doc/BRIEF.md
# Seven-to-one display link deserializer

This block turns a set of serial display lanes back into parallel pixel words. Every lane carries seven bit slots in each link clock period. A bit-rate clock, already phase-aligned to the link clock by an external PLL, samples all lanes on each of its edges. The block counts the slots from the link clock rising edge, gathers seven bits per lane, and at the last slot moves the whole word into a holding register. The holding register drives the colour and control outputs. It also produces a recovered pixel clock whose falling edge falls in the middle of each stable word.

A parameter selects between two modes. The wide mode has four lanes and produces 28 bits: three 8-bit colours and four control bits. The narrow mode has three lanes and produces 21 bits: three 6-bit colours and three control bits. Narrow colours are left-justified on the 8-bit colour ports. The outputs stay low until a lock interval, counted in link clock periods, has elapsed after power-up. An active-low power-down input forces every output low and restarts the lock interval. If the link clock stops, the last word stays on the outputs.

Top module: `drx_deser`

## Requirements
- R1: Every lane is sampled on each bit clock edge. Slot 0 is the bit sampled on the first bit clock edge that sees the link clock high after seeing it low. Slots 1 to 6 follow on the next six edges.
- R2: Wide mode (NARROW=0, 4 lanes): slot k of lane n becomes word bit 7n+k. red_o=word[7:0], grn_o=word[15:8], blu_o=word[23:16] and ctl_o=word[27:24]. In ctl_o, bit 0 is horizontal sync, bit 1 is vertical sync, bit 2 is data enable and bit 3 is a spare control bit.
- R3: Narrow mode (NARROW=1, 3 lanes): slot k of lane n becomes word bit 7n+k. red_o[7:2]=word[5:0], grn_o[7:2]=word[11:6], blu_o[7:2]=word[17:12] and ctl_o[2:0]=word[20:18]. Bits [1:0] of each colour and ctl_o[3] are 0.
- R4: The outputs change only on the bit clock edge that samples slot 6, which is once per link period. During slots 0 to 5 of the next period they keep the previous word.
- R5: pix_clk_o rises on the same edge as the word update. It is high for the four bit periods that begin at slot 6, and low after the edges that sample slots 3, 4 and 5. Its falling edge is therefore the data strobe.
- R6: While pd_ni is low, all colour and control outputs, pix_clk_o and valid_o are 0 without waiting for a clock edge. The lock interval restarts.
- R7: After pd_ni goes high, the link period whose slot 0 is the LOCK_CYC-th link clock rising edge is the first word presented. valid_o rises on that slot 0 edge. Before that edge, all data outputs are 0.
- R8: When the link clock stays low, the outputs keep the last word, valid_o stays high and pix_clk_o goes low.
- R9: A link clock rising edge that arrives before slot 6 restarts counting at slot 0. The partial word is discarded and the outputs do not change.
- R10: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the link clock, phase-aligned |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_clk_i | input | 1 | Link clock as seen in the bit-clock domain |
| lane_i | input | 4 (3 when NARROW=1) | Serial data lanes |
| pd_ni | input | 1 | Active-low power-down |
| red_o | output | 8 | Red colour field |
| grn_o | output | 8 | Green colour field |
| blu_o | output | 8 | Blue colour field |
| ctl_o | output | 4 | Control bits: hsync, vsync, data enable, spare |
| pix_clk_o | output | 1 | Recovered pixel clock; falling edge strobes the data |
| valid_o | output | 1 | High once locked and not powered down |

## Verification
A wide instance and a narrow instance are driven by the same serial stream. The stream is generated from a reference word, with lane n slot k carrying word bit 7n+k. A walking one through all 28 word bits pins every lane-and-slot position to a single output bit in each mode. All-ones, all-zeros and alternating words, together with pseudo-random words, expose swapped or stuck bits that a single one cannot reveal. Separate runs cover a truncated link period, a stopped link clock, and power-down in the middle of traffic followed by re-lock. These distinguish discarding a partial word from loading it, freezing the outputs from clearing them, and a restarted lock count from a retained one.

// File: rtl/drx_pkg.sv
`timescale 1ns/1ps
package drx_pkg;
  localparam int unsigned SLOTS     = 7;
  localparam int unsigned SLOT_W    = 3;
  localparam logic [SLOT_W-1:0] SLOT_IDLE = 3'd7;
  localparam logic [SLOT_W-1:0] SLOT_LAST = 3'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] CLK_HI_N  = 3'd3; // slots 0..2 plus last keep pixel clock high

  // output word bit for a lane/slot pair
  function automatic int unsigned word_bit(int unsigned lane, int unsigned slot);
    return lane * SLOTS + slot;
  endfunction
endpackage

// File: rtl/drx_framer.sv
`timescale 1ns/1ps
module drx_framer
  import drx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_clk_i,
  output logic rise_o,
  output logic load_o,
  output logic pix_o
);
  logic              link_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] cur_slot;

  assign rise_o   = link_clk_i & ~link_q;
  assign cur_slot = rise_o ? '0 : slot_q;
  assign load_o   = (cur_slot == SLOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b0;
      slot_q <= SLOT_IDLE;
      pix_o  <= 1'b0;
    end else begin
      link_q <= link_clk_i;
      // park at idle after the last slot until the next link edge
      slot_q <= (cur_slot >= SLOT_LAST) ? SLOT_IDLE : cur_slot + 3'd1;
      pix_o  <= (cur_slot == SLOT_LAST) || (cur_slot < CLK_HI_N);
    end
  end

  // R1 / R9: a link rising edge always restarts at slot 0
  a_r9_slot_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> (slot_q == 3'd1));

  // R8: without a link edge the counter stays parked and the pixel clock low
  a_r8_idle_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == SLOT_IDLE && !rise_o) |=> (slot_q == SLOT_IDLE && !pix_o));
endmodule

// File: rtl/drx_lane_shift.sv
`timescale 1ns/1ps
module drx_lane_shift
  import drx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  output logic [SLOTS-1:0] word_o
);
  localparam int unsigned SR_W = SLOTS - 1;

  logic [SR_W-1:0] sr_q;

  // shift right so the earliest slot settles at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {din_i, sr_q[SR_W-1:1]};
  end

  assign word_o = {din_i, sr_q};
endmodule

// File: rtl/drx_lock.sv
`timescale 1ns/1ps
module drx_lock #(
  parameter int unsigned LOCK_CYC = 850000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic rise_i,
  output logic locked_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LOCK_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!pd_ni)            cnt_q <= '0;
    else if (rise_i && !locked_o) cnt_q <= cnt_q + 1'b1;
  end

  assign locked_o = (cnt_q == CNT_END);

  a_r6_pd_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (cnt_q == '0 && !locked_o));

  a_r7_lock_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(rise_i) && $past(pd_ni)));
endmodule

// File: rtl/drx_deser.sv
`timescale 1ns/1ps
module drx_deser
  import drx_pkg::*;
#(
  parameter bit          NARROW   = 1'b0,
  parameter int unsigned LOCK_CYC = 850000,
  localparam int unsigned LANES   = NARROW ? 3 : 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_clk_i,
  input  logic [LANES-1:0] lane_i,
  input  logic             pd_ni,
  output logic [7:0]       red_o,
  output logic [7:0]       grn_o,
  output logic [7:0]       blu_o,
  output logic [3:0]       ctl_o,
  output logic             pix_clk_o,
  output logic             valid_o
);
  localparam int unsigned WORD_W  = LANES * SLOTS;
  localparam int unsigned COL_W   = NARROW ? 6 : 8;
  localparam int unsigned CTL_W   = NARROW ? 3 : 4;
  localparam int unsigned COL_PAD = 8 - COL_W;
  localparam int unsigned CTL_PAD = 4 - CTL_W;

  logic              rise, load, pix_q, locked;
  logic [SLOTS-1:0]  lane_word [LANES];
  logic [WORD_W-1:0] word_nx, hold_q, word_vis;

  drx_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .link_clk_i (link_clk_i),
    .rise_o     (rise),
    .load_o     (load),
    .pix_o      (pix_q)
  );

  drx_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_ni    (pd_ni),
    .rise_i   (rise),
    .locked_o (locked)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    drx_lane_shift u_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (lane_i[g]),
      .word_o (lane_word[g])
    );
    assign word_nx[word_bit(g, 0) +: SLOTS] = lane_word[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= '0;
    else if (!pd_ni)          hold_q <= '0;
    else if (load && locked)  hold_q <= word_nx;
  end

  // power-down gating is combinational so the outputs drop at once
  assign word_vis  = pd_ni ? hold_q : '0;
  assign pix_clk_o = pix_q & pd_ni;
  assign valid_o   = locked & pd_ni;

  if (NARROW) begin : g_narrow
    assign red_o = {word_vis[0*COL_W +: COL_W], {COL_PAD{1'b0}}};
    assign grn_o = {word_vis[1*COL_W +: COL_W], {COL_PAD{1'b0}}};
    assign blu_o = {word_vis[2*COL_W +: COL_W], {COL_PAD{1'b0}}};
    assign ctl_o = {{CTL_PAD{1'b0}}, word_vis[3*COL_W +: CTL_W]};
  end else begin : g_wide
    assign red_o = word_vis[0*COL_W +: COL_W];
    assign grn_o = word_vis[1*COL_W +: COL_W];
    assign blu_o = word_vis[2*COL_W +: COL_W];
    assign ctl_o = word_vis[3*COL_W +: CTL_W];
  end

  // R4: the held word moves only on a slot-6 edge
  a_r4_update_on_last_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ni && $past(pd_ni) && hold_q != $past(hold_q)) |-> $past(load));

  // R5: every visible word change coincides with a pixel clock rise
  a_r5_change_with_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ni && $past(pd_ni) && hold_q != $past(hold_q)) |-> (pix_clk_o && !$past(pix_clk_o)));

  // R7 / R10: nothing shows on the data outputs while not valid
  a_r7_quiet_until_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (word_vis == '0));
endmodule

// File: tb/drx_deser_tb.sv
`timescale 1ns/1ps
module drx_deser_tb;
  localparam int unsigned LOCK = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link = 1'b0;
  logic       pd_n = 1'b1;
  logic [3:0] lanes = '0;

  logic [7:0] w_red, w_grn, w_blu, n_red, n_grn, n_blu;
  logic [3:0] w_ctl, n_ctl;
  logic       w_pix, w_val, n_pix, n_val;

  int errors = 0;
  int checks = 0;
  int frames_since_pd = 0;
  logic [27:0] exp_w = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  drx_deser #(.NARROW(1'b0), .LOCK_CYC(LOCK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .link_clk_i(link), .lane_i(lanes), .pd_ni(pd_n),
    .red_o(w_red), .grn_o(w_grn), .blu_o(w_blu), .ctl_o(w_ctl),
    .pix_clk_o(w_pix), .valid_o(w_val));

  drx_deser #(.NARROW(1'b1), .LOCK_CYC(LOCK)) u_dut_nar (
    .clk_i(clk), .rst_ni(rst_n), .link_clk_i(link), .lane_i(lanes[2:0]), .pd_ni(pd_n),
    .red_o(n_red), .grn_o(n_grn), .blu_o(n_blu), .ctl_o(n_ctl),
    .pix_clk_o(n_pix), .valid_o(n_val));

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [27:0] wide_fields(input logic [27:0] w);
    return {w[7:0], w[15:8], w[23:16], w[27:24]};
  endfunction

  function automatic logic [27:0] nar_fields(input logic [27:0] w);
    return {w[5:0], 2'b00, w[11:6], 2'b00, w[17:12], 2'b00, 1'b0, w[20:18]};
  endfunction

  task automatic check_words(input string req);
    check(req, "wide fields", {4'h0, w_red, w_grn, w_blu, w_ctl}, {4'h0, wide_fields(exp_w)});
    check(req, "narrow fields", {4'h0, n_red, n_grn, n_blu, n_ctl}, {4'h0, nar_fields(exp_w)});
  endtask

  // reference serializer: lane n slot k carries word bit 7n+k
  task automatic run_frame(input logic [27:0] fw, input int nslots, input int link_hi);
    bit locked_now;
    locked_now = 1'b0;
    for (int k = 0; k < nslots; k++) begin
      @(negedge clk);
      link = (k < link_hi);
      for (int n = 0; n < 4; n++) lanes[n] = fw[7*n + k];
      @(posedge clk);
      #1;
      if (k == 0) begin
        if (pd_n) frames_since_pd++;
        locked_now = (frames_since_pd >= LOCK);
      end
      if (k < 6) begin
        check_words("R4 hold mid-period");
        check("R5", "pix low/high phase", {31'd0, w_pix}, {31'd0, pd_n && (k < 3)});
      end else begin
        if (locked_now && pd_n) exp_w = fw;
        check_words("R1 R2 R3 word");
        check("R5", "pix rises with word", {30'd0, w_pix, n_pix}, {30'd0, pd_n, pd_n});
        check("R7", "valid", {30'd0, w_val, n_val}, {30'd0, locked_now && pd_n, locked_now && pd_n});
      end
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #100us;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check_words("R10 reset");
    check("R10", "pix and valid", {28'd0, w_pix, n_pix, w_val, n_val}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 lock interval: frames 1..LOCK-1 stay quiet, frame LOCK appears
    for (int f = 0; f < int'(LOCK); f++) run_frame(28'h9A5_3C71 + 28'(f), 7, 4);

    // walking one across every lane/slot position (R1 R2 R3)
    for (int b = 0; b < 28; b++) run_frame(28'd1 << b, 7, 4);

    // fixed patterns
    run_frame(28'hFFF_FFFF, 7, 4);
    run_frame(28'h000_0000, 7, 4);
    run_frame(28'h555_5555, 7, 4);
    run_frame(28'hAAA_AAAA, 7, 4);

    // pseudo-random words
    for (int i = 0; i < 40; i++) begin
      seed = next_rand(seed);
      run_frame(seed[27:0], 7, 4);
    end

    // R9 truncated period: partial word discarded
    run_frame(28'h0F0_F0F0, 3, 2);
    check_words("R9 partial discarded");
    run_frame(28'h123_4567, 7, 4);

    // R8 link clock stops: last word held
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      link = 1'b0;
      lanes = 4'(i);
      @(posedge clk);
    end
    #1;
    check_words("R8 frozen");
    check("R8", "pix low when stopped", {30'd0, w_pix, n_pix}, 32'd0);
    check("R8", "valid stays high", {30'd0, w_val, n_val}, 32'd3);
    run_frame(28'h765_4321, 7, 4);

    // R6 power-down mid-traffic, then re-lock
    @(negedge clk);
    pd_n = 1'b0;
    #1;
    exp_w = '0;
    frames_since_pd = 0;
    check_words("R6 immediate low");
    check("R6", "pix and valid low", {28'd0, w_pix, n_pix, w_val, n_val}, 32'd0);
    run_frame(28'hFFF_FFFF, 7, 4);
    pd_n = 1'b1;
    for (int f = 0; f < int'(LOCK) + 2; f++) run_frame(28'h0C3_A5E1 ^ 28'(f * 77), 7, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule